// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the register-level steps a 32-bit core takes on entry to an exception. A one-cycle start pulse brings in a cause code, the candidate vector numbers, the current program counter, the pending delay-slot length and the state registers. In the cycle after the start is accepted, the sequencer does several things at once. It writes the return address into the exception or non-maskable return register. It writes the exception-status register and pushes the mode history in the status register. When the core was in user mode, it also swaps the stack pointers.

It then fetches the handler address from the vector table over a valid/ready request channel with a separate data-valid response. The returned word becomes the new program counter, and a one-cycle completion pulse follows. Each register output comes with a write strobe that the surrounding core uses to commit the value into its own register file.

Top module: `exc_entry_seq`

## Requirements
- R1: The vector is chosen by `cause_i`: 0 break trap uses `trap_vec_i`, 1 non-maskable uses vector 0, 2 bus fault uses `fault_vec_i`, 3 external interrupt uses `irq_vec_i`.
- R2: On entry, the return address goes to `erp_o` with `erp_we_o` for causes 0, 2 and 3, and to `nrp_o` with `nrp_we_o` for cause 1. The other return register keeps its value.
- R3: The saved return address is `pc_i - dslot_i` (32-bit wrap). When `dslot_i` is non-zero, `dslot_clr_o` pulses in the update cycle.
- R4: `exs_o` is written with the low 8 bits of the vector in bits 15:8, and every other bit is zero.
- R5: `ccs_o` becomes ((s & 0xC0000000) | ((s << 12) >> 2)) & ~0x3FF in 32-bit arithmetic. Here s is `ccs_i`, except that for cause 1 bit 30 (the M bit) is first cleared. The user flag at bit 6 is therefore cleared.
- R6: If bit 6 of `ccs_i` is set, `usp_o` takes `sp_i`, `sp_o` takes `ksp_i` and `stk_we_o` pulses. Otherwise both outputs hold and no strobe is raised.
- R7: After the update cycle, `mem_req_valid_o` is raised with address `vbr_i + vector*4` and held, with a stable address, until `mem_req_ready_i`. A `mem_rsp_valid_i` that arrives before the request is accepted is ignored.
- R8: The edge that samples `mem_rsp_valid_i` after acceptance loads `mem_rsp_data_i` into `pc_o` and raises `done_o` for exactly one cycle.
- R9: `busy_o` is high from the cycle after the start is accepted up to the response edge. A start pulse while busy has no effect.
- R10: `pend_o` shows {0, cause} during an entry and returns to 3'b100 (none) when `done_o` rises.
- R11: After reset, all register outputs are zero, `pend_o` is 3'b100, and all strobes, `busy_o`, `done_o` and `mem_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an entry (accepted only when idle) |
| cause_i | input | 2 | Cause code |
| trap_vec_i | input | VEC_W | Break trap vector |
| fault_vec_i | input | VEC_W | Bus fault vector |
| irq_vec_i | input | VEC_W | External interrupt vector |
| pc_i | input | 32 | Current program counter |
| dslot_i | input | DS_W | Pending delay-slot length, 0 when none |
| ccs_i | input | 32 | Current status register |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Kernel stack pointer |
| vbr_i | input | 32 | Vector table base |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dslot_clr_o | output | 1 | Clear the delay-slot state |
| erp_we_o | output | 1 | Exception return register written |
| nrp_we_o | output | 1 | Non-maskable return register written |
| upd_we_o | output | 1 | Status and exception-status written |
| stk_we_o | output | 1 | Stack pointers swapped |
| erp_o | output | 32 | Exception return register |
| nrp_o | output | 32 | Non-maskable return register |
| exs_o | output | 32 | Exception-status register |
| ccs_o | output | 32 | New status register |
| sp_o | output | 32 | New stack pointer |
| usp_o | output | 32 | Saved user stack pointer |
| pc_o | output | 32 | Handler program counter |
| pend_o | output | 3 | Pending cause, 3'b100 when none |
| mem_req_valid_o | output | 1 | Vector read request valid |
| mem_req_addr_o | output | 32 | Vector read address |
| mem_req_ready_i | input | 1 | Vector read request accepted |
| mem_rsp_valid_i | input | 1 | Vector read data valid |
| mem_rsp_data_i | input | 32 | Vector read data |

## Verification
Two events can land in the same cycle. A second start pulse can arrive while the vector fetch is outstanding. A response-valid can arrive while the request is still stalled by a low ready. The bench provokes both in one entry by holding ready low for several cycles. During that stall it pulses start with a different cause and raises response-valid with a wrong data word. It then judges that the register strobes stay low, that the pending cause and request address do not move, that the program counter is untouched and that busy stays high. The later real response must still load the correct handler address.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VEC_W     = 8,
  parameter int DS_W      = 3,
  parameter int UFLAG_BIT = 6,
  parameter int MFLAG_BIT = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       cause_i,
  input  logic [VEC_W-1:0] trap_vec_i,
  input  logic [VEC_W-1:0] fault_vec_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic [31:0]      pc_i,
  input  logic [DS_W-1:0]  dslot_i,
  input  logic [31:0]      ccs_i,
  input  logic [31:0]      sp_i,
  input  logic [31:0]      ksp_i,
  input  logic [31:0]      vbr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             dslot_clr_o,
  output logic             erp_we_o,
  output logic             nrp_we_o,
  output logic             upd_we_o,
  output logic             stk_we_o,
  output logic [31:0]      erp_o,
  output logic [31:0]      nrp_o,
  output logic [31:0]      exs_o,
  output logic [31:0]      ccs_o,
  output logic [31:0]      sp_o,
  output logic [31:0]      usp_o,
  output logic [31:0]      pc_o,
  output logic [2:0]       pend_o,
  output logic             mem_req_valid_o,
  output logic [31:0]      mem_req_addr_o,
  input  logic             mem_req_ready_i,
  input  logic             mem_rsp_valid_i,
  input  logic [31:0]      mem_rsp_data_i
);
  localparam logic [1:0] C_BRK  = 2'd0;
  localparam logic [1:0] C_NMI  = 2'd1;
  localparam logic [1:0] C_BUS  = 2'd2;
  localparam logic [2:0] P_NONE = 3'b100;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  logic [VEC_W-1:0] vec_sel;
  logic [31:0]      vec32, ret_addr, ccs_m, ccs_sh;
  logic             accept, is_nmi;

  assign accept   = (state == S_IDLE) && start_i;
  assign is_nmi   = (cause_i == C_NMI);
  assign vec32    = 32'(vec_sel);
  assign ret_addr = pc_i - 32'(dslot_i);
  assign ccs_sh   = ((ccs_m & 32'hC000_0000) | ((ccs_m << 12) >> 2)) & ~32'h0000_03FF;

  assign busy_o          = (state != S_IDLE);
  assign mem_req_valid_o = (state == S_REQ);

  always_comb begin
    case (cause_i)
      C_BRK:   vec_sel = trap_vec_i;
      C_NMI:   vec_sel = '0;
      C_BUS:   vec_sel = fault_vec_i;
      default: vec_sel = irq_vec_i;
    endcase
    ccs_m = ccs_i;
    if (is_nmi) ccs_m[MFLAG_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      done_o         <= 1'b0;
      dslot_clr_o    <= 1'b0;
      erp_we_o       <= 1'b0;
      nrp_we_o       <= 1'b0;
      upd_we_o       <= 1'b0;
      stk_we_o       <= 1'b0;
      erp_o          <= '0;
      nrp_o          <= '0;
      exs_o          <= '0;
      ccs_o          <= '0;
      sp_o           <= '0;
      usp_o          <= '0;
      pc_o           <= '0;
      pend_o         <= P_NONE;
      mem_req_addr_o <= '0;
    end else begin
      done_o      <= 1'b0;
      dslot_clr_o <= 1'b0;
      erp_we_o    <= 1'b0;
      nrp_we_o    <= 1'b0;
      upd_we_o    <= 1'b0;
      stk_we_o    <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (is_nmi) begin
            nrp_o    <= ret_addr;
            nrp_we_o <= 1'b1;
          end else begin
            erp_o    <= ret_addr;
            erp_we_o <= 1'b1;
          end
          exs_o       <= {16'h0000, vec32[7:0], 8'h00};
          ccs_o       <= ccs_sh;
          upd_we_o    <= 1'b1;
          dslot_clr_o <= (dslot_i != '0);
          if (ccs_i[UFLAG_BIT]) begin
            usp_o    <= sp_i;
            sp_o     <= ksp_i;
            stk_we_o <= 1'b1;
          end
          pend_o         <= {1'b0, cause_i};
          mem_req_addr_o <= vbr_i + (vec32 << 2);
          state          <= S_REQ;
        end
        S_REQ: if (mem_req_ready_i) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          pc_o   <= mem_rsp_data_i;
          done_o <= 1'b1;
          pend_o <= P_NONE;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module exc_entry_seq_chk #(
  parameter int UFLAG_BIT = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic        erp_we_o,
  input logic        nrp_we_o,
  input logic        upd_we_o,
  input logic        stk_we_o,
  input logic [31:0] exs_o,
  input logic [31:0] ccs_o,
  input logic [31:0] sp_o,
  input logic [31:0] ksp_i,
  input logic [2:0]  pend_o,
  input logic        mem_req_valid_o,
  input logic [31:0] mem_req_addr_o,
  input logic        mem_req_ready_i
);
  assert_one_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(erp_we_o && nrp_we_o));
  assert_nmi_vector_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nrp_we_o |-> exs_o[15:8] == 8'h00);
  assert_exs_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we_o |-> (exs_o[31:16] == 16'h0000) && (exs_o[7:0] == 8'h00));
  assert_ccs_low_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we_o |-> (ccs_o[9:0] == 10'h000) && !ccs_o[UFLAG_BIT]);
  assert_kernel_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we_o |-> sp_o == $past(ksp_i));
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !upd_we_o);
  assert_pend_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && (pend_o == 3'b100));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.UFLAG_BIT(UFLAG_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .erp_we_o(erp_we_o), .nrp_we_o(nrp_we_o), .upd_we_o(upd_we_o), .stk_we_o(stk_we_o),
  .exs_o(exs_o), .ccs_o(ccs_o), .sp_o(sp_o), .ksp_i(ksp_i), .pend_o(pend_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
  .mem_req_ready_i(mem_req_ready_i)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start_i = 0, mem_req_ready_i = 0, mem_rsp_valid_i = 0;
  logic [1:0] cause_i = 0;
  logic [7:0] trap_vec_i = 0, fault_vec_i = 0, irq_vec_i = 0;
  logic [31:0] pc_i = 0, ccs_i = 0, sp_i = 0, ksp_i = 0, vbr_i = 0, mem_rsp_data_i = 0;
  logic [2:0] dslot_i = 0;
  logic busy_o, done_o, dslot_clr_o, erp_we_o, nrp_we_o, upd_we_o, stk_we_o, mem_req_valid_o;
  logic [31:0] erp_o, nrp_o, exs_o, ccs_o, sp_o, usp_o, pc_o, mem_req_addr_o;
  logic [2:0] pend_o;

  exc_entry_seq i_exc_entry_seq (.*);

  typedef struct packed {
    logic [1:0] cause; logic [7:0] tv, fv, iv; logic [31:0] pc; logic [2:0] ds;
    logic [31:0] ccs, sp, ksp, vbr, hdl;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{2'd0, 8'h21, 8'h00, 8'h00, 32'h0000_1000, 3'd0, 32'h0000_0040, 32'hAAAA_0000, 32'h8000_0000, 32'h0001_0000, 32'h4000_0100},
    '{2'd1, 8'h55, 8'h66, 8'h77, 32'h0000_2004, 3'd2, 32'hC000_F0FF, 32'h1234_5678, 32'h8000_1000, 32'h0002_0000, 32'h4000_0200},
    '{2'd2, 8'h11, 8'h3C, 8'h22, 32'h0000_3008, 3'd2, 32'hFFFF_FFBF, 32'h5555_0000, 32'h8000_2000, 32'h0003_0000, 32'h4000_0300},
    '{2'd3, 8'h01, 8'h02, 8'hFF, 32'hDEAD_BEE0, 3'd0, 32'h4000_0000, 32'h0BAD_F00D, 32'h8000_3000, 32'hFFFF_FC00, 32'h4000_0400},
    '{2'd3, 8'h01, 8'h02, 8'h00, 32'h0000_0000, 3'd2, 32'h0008_0041, 32'h7777_0000, 32'h8000_4000, 32'h0004_0000, 32'h4000_0500},
    '{2'd0, 8'h80, 8'h00, 8'h00, 32'h0000_6000, 3'd4, 32'h8001_2345, 32'h9999_0000, 32'h8000_5000, 32'h0005_0000, 32'h4000_0600}
  };

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [31:0] e_erp = 0, e_nrp = 0, e_sp = 0, e_usp = 0, e_pc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pick_vec(vec_t v);
    case (v.cause)
      2'd0: return v.tv;
      2'd1: return 8'h00;
      2'd2: return v.fv;
      default: return v.iv;
    endcase
  endfunction

  function automatic logic [31:0] new_ccs(vec_t v);
    logic [31:0] s, t;
    s = v.ccs;
    if (v.cause == 2'd1) s[30] = 1'b0;
    t = s << 12;
    return ((s & 32'hC000_0000) | (t >> 2)) & ~32'h0000_03FF;
  endfunction

  task automatic run(input vec_t v, input int stall, input bit disturb);
    logic [7:0] vec;
    logic [31:0] ret, addr;
    vec  = pick_vec(v);
    ret  = v.pc - {29'd0, v.ds};
    addr = v.vbr + {22'd0, vec, 2'b00};
    @(negedge clk);
    cause_i = v.cause; trap_vec_i = v.tv; fault_vec_i = v.fv; irq_vec_i = v.iv;
    pc_i = v.pc; dslot_i = v.ds; ccs_i = v.ccs; sp_i = v.sp; ksp_i = v.ksp; vbr_i = v.vbr;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (v.cause == 2'd1) e_nrp = ret; else e_erp = ret;
    if (v.ccs[6]) begin e_usp = v.sp; e_sp = v.ksp; end
    chk("R1 R4 exs", exs_o, {16'h0, vec, 8'h0});
    chk("R2 erp", erp_o, e_erp);
    chk("R2 nrp", nrp_o, e_nrp);
    chk("R2 strobes", {30'd0, erp_we_o, nrp_we_o}, {30'd0, v.cause != 2'd1, v.cause == 2'd1});
    chk("R3 dslot_clr", {31'd0, dslot_clr_o}, {31'd0, v.ds != 0});
    chk("R5 ccs", ccs_o, new_ccs(v));
    chk("R6 sp", sp_o, e_sp);
    chk("R6 usp", usp_o, e_usp);
    chk("R6 stk_we", {31'd0, stk_we_o}, {31'd0, v.ccs[6]});
    chk("R7 req", {31'd0, mem_req_valid_o}, 32'd1);
    chk("R7 addr", mem_req_addr_o, addr);
    chk("R10 pend", {29'd0, pend_o}, {30'd0, v.cause});
    for (int k = 0; k < stall; k++) begin
      if (disturb && k == 0) begin
        start_i = 1; cause_i = ~v.cause; pc_i = 32'h0BAD_0000;
        mem_rsp_valid_i = 1; mem_rsp_data_i = 32'hFFFF_EEEE;
      end
      @(negedge clk);
      start_i = 0; mem_rsp_valid_i = 0;
      chk("R7 held", {31'd0, mem_req_valid_o}, 32'd1);
      chk("R7 stable", mem_req_addr_o, addr);
      if (disturb && k == 0) begin
        chk("R9 no upd", {30'd0, upd_we_o, erp_we_o | nrp_we_o}, 32'd0);
        chk("R9 pend", {29'd0, pend_o}, {30'd0, v.cause});
        chk("R7 early rsp ignored", pc_o, e_pc);
        chk("R9 busy", {31'd0, busy_o}, 32'd1);
      end
    end
    mem_req_ready_i = 1;
    @(negedge clk);
    mem_req_ready_i = 0;
    chk("R7 req dropped", {31'd0, mem_req_valid_o}, 32'd0);
    chk("R9 busy wait", {31'd0, busy_o}, 32'd1);
    mem_rsp_valid_i = 1; mem_rsp_data_i = v.hdl;
    @(negedge clk);
    mem_rsp_valid_i = 0;
    e_pc = v.hdl;
    chk("R8 pc", pc_o, e_pc);
    chk("R8 done", {31'd0, done_o}, 32'd1);
    chk("R9 idle", {31'd0, busy_o}, 32'd0);
    chk("R10 none", {29'd0, pend_o}, 32'd4);
    @(negedge clk);
    chk("R8 done pulse", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 outs", erp_o | nrp_o | exs_o | ccs_o | sp_o | usp_o | pc_o, 32'd0);
    chk("R11 ctl", {25'd0, busy_o, done_o, mem_req_valid_o, upd_we_o, erp_we_o, nrp_we_o, stk_we_o}, 32'd0);
    chk("R11 pend", {29'd0, pend_o}, 32'd4);
    rst_n = 1;
    for (int i = 0; i < 6; i++) run(TBL[i], i % 3, 1'b0);
    run(TBL[1], 4, 1'b1);
    run(TBL[2], 3, 1'b1);
    rst_n = 0;
    @(negedge clk);
    chk("R11 reset again", {29'd0, pend_o}, 32'd4);
    chk("R11 pc cleared", pc_o, 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule